// File: doc/BRIEF.md
# Receive Filter Calibration Sequencer

This block trims an external pair of receive channel filters. It drives three trim codes: a gain balance code that brings the Q channel amplitude level with the I channel, an I cutoff code and a Q cutoff code. Each code is found by a binary search that runs from the most significant bit down to the least. An external amplitude estimator compares the measured tone amplitude with its target and returns a single result bit, `cmpGreater`. The sequencer asserts `testEn` while it works. It uses `toneHigh` to choose the tone: low for the in-band tone, high for the out-of-band tone. It uses `trimSel` to tell the estimator which code is under trial.

The balance search runs first, with the in-band tone. The I cutoff search follows, then the Q cutoff search, both with the out-of-band tone and both compared against the in-band reference. A run starts when reset is released and on every rising edge of the CDMA mode level, which marks entry into CDMA mode from FM mode or from power-down. `calDisable` blocks that trigger. When the run ends the three codes hold their values until the next start. The overall calibration time, in the tens of milliseconds, is set by the settle count applied at each trial bit.

Top module: `rxcal_seq`

## Requirements
- R1: While reset is asserted, `testEn` is 1, `toneHigh` is 0, `trimSel` is 0 and all three codes are 0. When reset is released, a calibration run starts.
- R2: `testEn` stays 1 for the whole run and goes to 0 when the run ends. While `testEn` is 0, `toneHigh` and `trimSel` are both 0.
- R3: During the balance search, `trimSel` is 0 and `toneHigh` is 0 (in-band tone).
- R4: After the balance search comes the I cutoff search (`trimSel` = 1), then the Q cutoff search (`trimSel` = 2). `toneHigh` is 1 for both, and `trimSel` never goes back to a lower value within a run.
- R5: Each code is searched from MSB to LSB. For each bit, the trial bit is set, and it is cleared again if `cmpGreater` is 1 when sampled. The result is the largest code for which the comparator reports "not greater", and only one code bit changes per step.
- R6: Each trial bit takes `settleCount` + 3 clock cycles: one cycle to set the bit, `settleCount` + 1 settle cycles, and one decide cycle. A triggered run therefore keeps `testEn` high for 24·(`settleCount` + 3) cycles, counted from the trigger edge.
- R7: After a run ends, the codes do not change whatever `cmpGreater` does.
- R8: A 0-to-1 change of `cdmaMode` starts a run and clears all three codes at the trigger edge. Holding `cdmaMode` high does not start another run.
- R9: While `calDisable` is 1, a rising edge of `cdmaMode` starts no run and leaves the codes unchanged.
- R10: A trigger that arrives during a run restarts the sequence at the MSB of the balance search. The timing of R6 is then counted from the new trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cdmaMode | input | 1 | CDMA mode level; a rising edge starts a run |
| calDisable | input | 1 | Blocks mode-entry triggers when 1 |
| settleCount | input | SETTLE_W | Extra settle cycles per trial bit |
| cmpGreater | input | 1 | 1 when the measured amplitude exceeds the target |
| testEn | output | 1 | High while calibration runs |
| toneHigh | output | 1 | 0 selects the in-band tone, 1 the out-of-band tone |
| trimSel | output | 2 | Code under trial: 0 balance, 1 I cutoff, 2 Q cutoff |
| balCode | output | CODE_W | I/Q gain balance trim code |
| fcICode | output | CODE_W | I channel cutoff trim code |
| fcQCode | output | CODE_W | Q channel cutoff trim code |

## Verification
The hardest case to reach is a trigger that lands partway through a search, where stale trial bits and a half-finished phase could leak into the restarted run. The bench starts a run and, after a fixed number of cycles partway through, loads fresh targets and produces a new rising edge of `cdmaMode`. It then checks that the codes read zero just after the edge, that the run lasts exactly the R6 count from the new edge, and that the results match the new targets. The comparator is modelled in the bench as "selected code greater than a random target", so each search must land exactly on its target. The targets are random, with 0, 255 and 128 as fixed corner values.

// File: rtl/rxcal_pkg.sv
package rxcal_pkg;
  typedef enum logic [1:0] {SEL_BAL = 2'd0, SEL_FCI = 2'd1, SEL_FCQ = 2'd2} trim_sel_e;
  typedef enum logic [1:0] {ST_SET, ST_WAIT, ST_DECIDE, ST_DONE} cal_state_e;

  // strobes from the sequencer to the code registers
  typedef struct packed {
    logic      clrAll;
    logic      setBit;
    logic      decide;
    logic      busy;
    trim_sel_e sel;
  } dp_strobe_t;
endpackage

// File: rtl/rxcal_ctrl.sv
module rxcal_ctrl
  import rxcal_pkg::*;
#(
  parameter int CODE_W   = 8,
  parameter int SETTLE_W = 16,
  localparam int IDX_W   = $clog2(CODE_W)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cdmaMode,
  input  logic                calDisable,
  input  logic [SETTLE_W-1:0] settleCount,
  output dp_strobe_t          strb,
  output logic [IDX_W-1:0]    bitIdx,
  output logic                testEn,
  output logic                toneHigh,
  output logic [1:0]          trimSel
);
  localparam logic [IDX_W-1:0] IDX_MSB = IDX_W'(CODE_W - 1);

  cal_state_e          state;
  trim_sel_e           sel;
  logic [SETTLE_W-1:0] cnt;
  logic                cdmaPrev;
  logic                trig;

  assign trig = cdmaMode && !cdmaPrev && !calDisable;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_SET;
      sel      <= SEL_BAL;
      bitIdx   <= IDX_MSB;
      cnt      <= '0;
      cdmaPrev <= 1'b1;
    end else begin
      cdmaPrev <= cdmaMode;
      if (trig) begin
        state  <= ST_SET;
        sel    <= SEL_BAL;
        bitIdx <= IDX_MSB;
      end else begin
        case (state)
          ST_SET: begin
            cnt   <= settleCount;
            state <= ST_WAIT;
          end
          ST_WAIT: begin
            if (cnt == '0) state <= ST_DECIDE;
            else           cnt   <= cnt - 1'b1;
          end
          ST_DECIDE: begin
            if (bitIdx == '0) begin
              bitIdx <= IDX_MSB;
              if (sel == SEL_FCQ) begin
                state <= ST_DONE;
              end else begin
                sel   <= (sel == SEL_BAL) ? SEL_FCI : SEL_FCQ;
                state <= ST_SET;
              end
            end else begin
              bitIdx <= bitIdx - 1'b1;
              state  <= ST_SET;
            end
          end
          default: state <= ST_DONE;
        endcase
      end
    end
  end

  always_comb begin
    strb.clrAll = trig;
    strb.setBit = (state == ST_SET) && !trig;
    strb.decide = (state == ST_DECIDE) && !trig;
    strb.busy   = (state != ST_DONE);
    strb.sel    = sel;
  end

  assign testEn   = (state != ST_DONE);
  assign toneHigh = testEn && (sel != SEL_BAL);
  assign trimSel  = testEn ? sel : SEL_BAL;

  // R5: bits are walked from MSB downward, one per decide
  p_msb_first_r5: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DECIDE && bitIdx != '0 && !trig) |=> bitIdx == IDX_W'($past(bitIdx) - 1'b1));
  // R6: settle counter is loaded from the programmed count
  p_settle_load_r6: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SET && !trig) |=> (state == ST_WAIT && cnt == $past(settleCount)));
  // R9: a disabled trigger leaves a finished sequencer idle
  p_disable_blocks_r9: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DONE && calDisable) |=> state == ST_DONE);
  // R10: any trigger restarts at the balance MSB
  p_restart_bal_r10: assert property (@(posedge clk) disable iff (!rstN)
    trig |=> (state == ST_SET && sel == SEL_BAL && bitIdx == IDX_MSB));
endmodule

// File: rtl/rxcal_dp.sv
module rxcal_dp
  import rxcal_pkg::*;
#(
  parameter int CODE_W  = 8,
  localparam int IDX_W  = $clog2(CODE_W),
  localparam int N_CODE = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  dp_strobe_t        strb,
  input  logic [IDX_W-1:0]  bitIdx,
  input  logic              cmpGreater,
  output logic [CODE_W-1:0] balCode,
  output logic [CODE_W-1:0] fcICode,
  output logic [CODE_W-1:0] fcQCode
);
  logic [CODE_W-1:0] codeReg [N_CODE];

  for (genvar g = 0; g < N_CODE; g++) begin : g_code
    logic hit;
    assign hit = (strb.sel == trim_sel_e'(2'(g)));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                          codeReg[g]         <= '0;
      else if (strb.clrAll)               codeReg[g]         <= '0;
      else if (hit && strb.setBit)        codeReg[g][bitIdx] <= 1'b1;
      else if (hit && strb.decide && cmpGreater) codeReg[g][bitIdx] <= 1'b0;
    end

    // R7: codes hold once the run is over
    p_frozen_r7: assert property (@(posedge clk) disable iff (!rstN)
      (!strb.busy && !strb.clrAll) |=> $stable(codeReg[g]));
    // R5: a search step moves at most one code bit
    p_one_bit_step_r5: assert property (@(posedge clk) disable iff (!rstN)
      (strb.busy && !strb.clrAll) |=> $countones(codeReg[g] ^ $past(codeReg[g])) <= 1);
  end

  assign balCode = codeReg[0];
  assign fcICode = codeReg[1];
  assign fcQCode = codeReg[2];
endmodule

// File: rtl/rxcal_seq.sv
module rxcal_seq
  import rxcal_pkg::*;
#(
  parameter int CODE_W   = 8,
  parameter int SETTLE_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cdmaMode,
  input  logic                calDisable,
  input  logic [SETTLE_W-1:0] settleCount,
  input  logic                cmpGreater,
  output logic                testEn,
  output logic                toneHigh,
  output logic [1:0]          trimSel,
  output logic [CODE_W-1:0]   balCode,
  output logic [CODE_W-1:0]   fcICode,
  output logic [CODE_W-1:0]   fcQCode
);
  localparam int IDX_W = $clog2(CODE_W);

  dp_strobe_t       strb;
  logic [IDX_W-1:0] bitIdx;

  rxcal_ctrl #(.CODE_W(CODE_W), .SETTLE_W(SETTLE_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cdmaMode(cdmaMode), .calDisable(calDisable),
    .settleCount(settleCount), .strb(strb), .bitIdx(bitIdx),
    .testEn(testEn), .toneHigh(toneHigh), .trimSel(trimSel)
  );

  rxcal_dp #(.CODE_W(CODE_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .bitIdx(bitIdx), .cmpGreater(cmpGreater),
    .balCode(balCode), .fcICode(fcICode), .fcQCode(fcQCode)
  );
endmodule

// File: tb/rxcal_seq_tb.sv
module rxcal_seq_tb;
  localparam int CODE_W   = 8;
  localparam int SETTLE_W = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cdmaMode = 1'b0;
  logic calDisable = 1'b0;
  logic [SETTLE_W-1:0] settleCount = 16'd3;
  logic cmpGreater;
  logic testEn, toneHigh;
  logic [1:0] trimSel;
  logic [CODE_W-1:0] balCode, fcICode, fcQCode;
  logic [CODE_W-1:0] tgt [3];
  logic [CODE_W-1:0] curCode;

  int nChecks = 0;
  int nFail = 0;

  always #4 clk = ~clk;

  rxcal_seq #(.CODE_W(CODE_W), .SETTLE_W(SETTLE_W)) u_dut (
    .clk(clk), .rstN(rstN), .cdmaMode(cdmaMode), .calDisable(calDisable),
    .settleCount(settleCount), .cmpGreater(cmpGreater), .testEn(testEn),
    .toneHigh(toneHigh), .trimSel(trimSel), .balCode(balCode),
    .fcICode(fcICode), .fcQCode(fcQCode)
  );

  // comparator model: measured amplitude rises with the code under trial
  assign curCode    = (trimSel == 2'd0) ? balCode : (trimSel == 2'd1) ? fcICode : fcQCode;
  assign cmpGreater = curCode > tgt[(trimSel > 2'd2) ? 2 : trimSel];

  function automatic int runCycles(int s);
    return 24 * (s + 3);
  endfunction

  task automatic chk(string req, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finishAll();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  endtask

  task automatic trigger();
    @(negedge clk) cdmaMode = 1'b0;
    @(negedge clk) cdmaMode = 1'b1;
    @(posedge clk);
    #2;
    chk("R8 codes cleared at trigger", {balCode, fcICode, fcQCode}, 0);
    chk("R10 restart in balance phase", {30'd0, trimSel}, 0);
  endtask

  // counts negedges with testEn high and watches the tone/phase rules
  task automatic waitDone(output int cyc, output int toneBad, output int orderBad);
    int lastSel = 0;
    cyc = 0; toneBad = 0; orderBad = 0;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (!testEn) break;
      cyc++;
      if (trimSel == 2'd0 && toneHigh) toneBad++;
      if (trimSel != 2'd0 && !toneHigh) toneBad++;
      if (int'(trimSel) < lastSel || trimSel == 2'd3) orderBad++;
      lastSel = int'(trimSel);
    end
  endtask

  task automatic checkResult(string tag);
    chk({"R5 balance code ", tag}, balCode, tgt[0]);
    chk({"R5 I cutoff code ", tag}, fcICode, tgt[1]);
    chk({"R5 Q cutoff code ", tag}, fcQCode, tgt[2]);
    chk({"R2 idle outputs ", tag}, {testEn, toneHigh, trimSel}, 0);
  endtask

  initial begin
    int cyc, toneBad, orderBad;
    logic [3*CODE_W-1:0] held;
    void'($urandom(32'd20240611));
    tgt[0] = 8'd90; tgt[1] = 8'd200; tgt[2] = 8'd17;

    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 testEn in reset", testEn, 1);
    chk("R1 tone and select in reset", {toneHigh, trimSel}, 0);
    chk("R1 codes in reset", {balCode, fcICode, fcQCode}, 0);
    rstN = 1'b1;
    waitDone(cyc, toneBad, orderBad);
    checkResult("after reset");
    chk("R3 R4 tone per phase after reset", toneBad, 0);

    // directed corners then random runs
    for (int r = 0; r < 6; r++) begin
      int s;
      case (r)
        0: begin tgt[0] = 8'd0;   tgt[1] = 8'd255; tgt[2] = 8'd128; end
        1: begin tgt[0] = 8'd255; tgt[1] = 8'd0;   tgt[2] = 8'd127; end
        default: for (int k = 0; k < 3; k++) tgt[k] = 8'($urandom_range(0, 255));
      endcase
      s = (r == 0) ? 0 : $urandom_range(0, 7);
      settleCount = 16'(s);
      trigger();
      waitDone(cyc, toneBad, orderBad);
      chk("R6 run length", cyc, runCycles(s));
      chk("R3 balance tone low", toneBad, 0);
      chk("R4 phase order", orderBad, 0);
      checkResult($sformatf("run %0d", r));
    end

    // R7: codes frozen while the comparator keeps changing
    held = {balCode, fcICode, fcQCode};
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      for (int k = 0; k < 3; k++) tgt[k] = 8'($urandom_range(0, 255));
    end
    chk("R7 codes frozen", {balCode, fcICode, fcQCode}, held);
    chk("R8 level high does not retrigger", testEn, 0);

    // R9: disabled trigger
    calDisable = 1'b1;
    @(negedge clk) cdmaMode = 1'b0;
    @(negedge clk) cdmaMode = 1'b1;
    repeat (20) @(negedge clk);
    chk("R9 no run while disabled", testEn, 0);
    chk("R9 codes kept while disabled", {balCode, fcICode, fcQCode}, held);
    calDisable = 1'b0;

    // R10: trigger partway through a run
    settleCount = 16'd5;
    trigger();
    repeat (70) @(negedge clk);
    chk("R10 still running before retrigger", testEn, 1);
    for (int k = 0; k < 3; k++) tgt[k] = 8'($urandom_range(0, 255));
    settleCount = 16'd2;
    trigger();
    waitDone(cyc, toneBad, orderBad);
    chk("R10 run length from retrigger", cyc, runCycles(2));
    chk("R4 phase order after retrigger", orderBad, 0);
    checkResult("after retrigger");

    finishAll();
  end

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog actual=expired expected=finished");
    finishAll();
  end
endmodule